// File: doc/BRIEF.md
# Serial Bus Adapter, SPI Master Side

This block joins a microcontroller whose SPI port works as a slave to a shared asynchronous serial bus. The adapter owns the SPI clock. The host loads one byte into its SPI shift register and asks for a transmission by pulling its request line low. The adapter then waits until the bus is idle. It sends a frame made of a start bit, eight data bits and a stop bit. During the eight data bits it clocks the host's byte out of the host and clocks back the bits it reads from the bus.

When the transfer ends, the host's shift register holds the byte that came back from the bus. The host compares that byte with the one it sent to find out whether another node overwrote a bit. Bits travel in the order the host shifts them. The first bit out of the host fills the first data slot on the bus, and the bus sends its data least significant bit first. Host firmware therefore mirrors the byte. The SPI side and the bus side share one bit rate. That rate comes from a strap-selected prescaler followed by a fixed count of prescaled ticks per bit.

Top module: `spim_bus_adapter`

## Requirements
- R1: While reset is held, `sck_o` is 0, `ctrl_busy_no` is 1, `bus_tx_o` is 1 and `host_miso_o` is 1.
- R2: A frame on `bus_tx_o` is a 0 start bit, then eight data bits, then a 1 stop bit. Data slot j carries the j-th bit that the host shifted out, so the first host bit goes in the first slot.
- R3: Each bit lasts BIT_TICKS prescaled ticks. One tick is 1, 2, 4 or 10 clocks when `div_sel_i` is 00, 01, 10 or 11.
- R4: Each frame has exactly eight SCK pulses, one in each data bit. SCK rises one prescaled tick after the middle of the data bit and falls one tick before the end of that bit. `sck_o` is 0 outside a frame.
- R5: In the middle of each data bit, `host_miso_o` takes the value of `bus_rx_i`. The host's shift register therefore ends the frame holding the byte reflected from the bus. This includes any bit that another node forced to 0.
- R6: `ctrl_busy_no` is 0 for exactly the ten bit periods of a frame, from the start of the start bit to the end of the stop bit. It is 1 at all other times.
- R7: A request made while `bus_idle_i` is 0 is remembered. No frame starts until `bus_idle_i` is 1. The frame then starts even if the host has already released `ctrl_req_ni`.
- R8: Request activity on `ctrl_req_ni` while a frame is running is ignored. It does not cause a second frame after the current one ends.
- R9: `bus_tx_o` is 1 (mark) whenever no frame is running.
- R10: A drop of `bus_idle_i` while a frame is running has no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, input to the prescaler |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Prescaler strap: 00=/1, 01=/2, 10=/4, 11=/10 |
| ctrl_req_ni | input | 1 | Host transmit request, active low |
| ctrl_busy_no | output | 1 | Low while a byte is active on the bus |
| bus_idle_i | input | 1 | High when the bus idle detector sees a free bus |
| sck_o | output | 1 | SPI clock driven toward the host |
| host_mosi_i | input | 1 | Serial data from the host (outgoing byte) |
| host_miso_o | output | 1 | Serial data to the host (reflected byte) |
| bus_tx_o | output | 1 | Data toward the bus driver; 1 is mark |
| bus_rx_i | input | 1 | Data from the bus receiver |

## Verification
The bench builds the adapter with BIT_TICKS set to 16 and SYNC_STAGES left at 2. With these values a frame is short enough that all four prescaler settings run within one run, including the slowest setting (/10, 1600 clocks per frame). The small tick count keeps the midpoint, SCK edges and bit boundaries a few ticks apart, so an error of one tick in any of them changes the measured offsets. Forced-zero bit patterns on the bus side show that the host receives the reflected byte and not its own.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 2;
  localparam int unsigned DIV_MAX    = 10;

  typedef enum logic {ST_IDLE, ST_FRAME} adapter_st_e;

  function automatic int unsigned div_factor(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/spim_prescaler.sv
module spim_prescaler import spim_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] div_sel_i,
  output logic       tick_o
);
  localparam int unsigned CW = $clog2(DIV_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = CW'(div_factor(div_sel_i) - 1);
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_bit_timer.sv
module spim_bit_timer import spim_pkg::*; #(
  parameter int unsigned BIT_TICKS = 128
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          run_i,
  input  logic                          tick_i,
  output logic [$clog2(FRAME_BITS)-1:0] bit_idx_o,
  output logic                          mid_o,
  output logic                          rise_o,
  output logic                          fall_o,
  output logic                          wrap_o
);
  localparam int unsigned TW   = $clog2(BIT_TICKS);
  localparam int unsigned BW   = $clog2(FRAME_BITS);
  localparam int unsigned HALF = BIT_TICKS / 2;

  logic [TW-1:0] tick_q;
  logic [BW-1:0] idx_q;
  logic          step;

  assign step   = run_i && tick_i;
  assign mid_o  = step && (tick_q == TW'(HALF - 1));
  assign rise_o = step && (tick_q == TW'(HALF));
  assign fall_o = step && (tick_q == TW'(BIT_TICKS - 2));
  assign wrap_o = step && (tick_q == TW'(BIT_TICKS - 1));
  assign bit_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      tick_q <= '0;
      idx_q  <= '0;
    end else if (wrap_o) begin
      tick_q <= '0;
      idx_q  <= (idx_q == BW'(FRAME_BITS - 1)) ? '0 : idx_q + 1'b1;
    end else if (step) begin
      tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/spim_bus_adapter.sv
module spim_bus_adapter import spim_pkg::*; #(
  parameter int unsigned BIT_TICKS   = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  input  logic       ctrl_req_ni,
  output logic       ctrl_busy_no,
  input  logic       bus_idle_i,
  output logic       sck_o,
  input  logic       host_mosi_i,
  output logic       host_miso_o,
  output logic       bus_tx_o,
  input  logic       bus_rx_i
);
  localparam int unsigned BW = $clog2(FRAME_BITS);

  logic          req_n_s, idle_s;
  adapter_st_e   st_q;
  logic          pend_q, start, tick;
  logic [BW-1:0] bit_idx, nxt_idx;
  logic          ev_mid, ev_rise, ev_fall, ev_wrap, in_data;

  spim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_req (
    .clk_i, .rst_ni, .d_i(ctrl_req_ni), .q_o(req_n_s)
  );
  spim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_idle (
    .clk_i, .rst_ni, .d_i(bus_idle_i), .q_o(idle_s)
  );

  // pending request survives release while the bus is occupied
  assign start = (st_q == ST_IDLE) && (pend_q || !req_n_s) && idle_s;

  spim_prescaler u_presc (
    .clk_i, .rst_ni, .clr_i(start), .div_sel_i, .tick_o(tick)
  );

  spim_bit_timer #(.BIT_TICKS(BIT_TICKS)) u_timer (
    .clk_i, .rst_ni,
    .start_i  (start),
    .run_i    (st_q == ST_FRAME),
    .tick_i   (tick),
    .bit_idx_o(bit_idx),
    .mid_o    (ev_mid),
    .rise_o   (ev_rise),
    .fall_o   (ev_fall),
    .wrap_o   (ev_wrap)
  );

  assign nxt_idx = bit_idx + 1'b1;
  assign in_data = (bit_idx >= BW'(1)) && (bit_idx <= BW'(DATA_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      pend_q       <= 1'b0;
      ctrl_busy_no <= 1'b1;
      bus_tx_o     <= 1'b1;
      sck_o        <= 1'b0;
      host_miso_o  <= 1'b1;
    end else if (start) begin
      st_q         <= ST_FRAME;
      pend_q       <= 1'b0;
      ctrl_busy_no <= 1'b0;
      bus_tx_o     <= 1'b0;
      sck_o        <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (!req_n_s) pend_q <= 1'b1;
    end else begin
      if (ev_mid && in_data)  host_miso_o <= bus_rx_i;
      if (ev_rise && in_data) sck_o <= 1'b1;
      if (ev_fall)            sck_o <= 1'b0;
      if (ev_wrap) begin
        if (bit_idx == BW'(FRAME_BITS - 1)) begin
          st_q         <= ST_IDLE;
          ctrl_busy_no <= 1'b1;
          bus_tx_o     <= 1'b1;
        end else if (nxt_idx <= BW'(DATA_BITS)) begin
          bus_tx_o <= host_mosi_i;
        end else begin
          bus_tx_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spim_bus_adapter_chk.sv
module spim_bus_adapter_chk import spim_pkg::*; #(
  parameter int unsigned BIT_TICKS = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] div_sel_i,
  input logic       ctrl_busy_no,
  input logic       sck_o,
  input logic       bus_tx_o
);
  int unsigned low_len_q;
  logic [3:0]  rise_cnt_q;
  logic        sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_len_q  <= 0;
      rise_cnt_q <= '0;
      sck_d_q    <= 1'b0;
    end else begin
      sck_d_q <= sck_o;
      if (ctrl_busy_no) begin
        low_len_q  <= 0;
        rise_cnt_q <= '0;
      end else begin
        low_len_q <= low_len_q + 1;
        if (sck_o && !sck_d_q) rise_cnt_q <= rise_cnt_q + 1'b1;
      end
    end
  end

  a_r6_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_busy_no) |-> low_len_q == FRAME_BITS * BIT_TICKS * div_factor(div_sel_i));

  a_r4_eight_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_busy_no) |-> rise_cnt_q == 4'(DATA_BITS));

  a_r4_sck_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_busy_no |-> !sck_o);

  a_r9_mark_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_busy_no |-> bus_tx_o);

  a_r2_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_busy_no) |-> !bus_tx_o);

  a_r2_stop_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_busy_no) |-> $past(bus_tx_o));
endmodule

bind spim_bus_adapter spim_bus_adapter_chk #(.BIT_TICKS(BIT_TICKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .div_sel_i   (div_sel_i),
  .ctrl_busy_no(ctrl_busy_no),
  .sck_o       (sck_o),
  .bus_tx_o    (bus_tx_o)
);

// File: tb/tb_spim_bus_adapter.sv
`timescale 1ns/1ps
module tb_spim_bus_adapter;
  localparam int BT   = 16;
  localparam int HALF = BT / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic req_n = 1'b1;
  logic idle = 1'b1;
  logic busy_n, sck, miso, tx, rx, mosi;
  logic force_now = 1'b0;

  always #2 clk = ~clk;

  spim_bus_adapter #(.BIT_TICKS(BT), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(div_sel),
    .ctrl_req_ni(req_n), .ctrl_busy_no(busy_n), .bus_idle_i(idle),
    .sck_o(sck), .host_mosi_i(mosi), .host_miso_o(miso),
    .bus_tx_o(tx), .bus_rx_i(rx)
  );

  assign rx = tx & ~force_now;

  // host SPI slave: latch on rise, shift on fall, MSB out first
  logic [7:0] hs = 8'h00;
  logic       rx_bit = 1'b0;
  assign mosi = hs[7];
  always @(posedge sck) rx_bit <= miso;
  always @(negedge sck) hs <= {hs[6:0], rx_bit};

  typedef struct { logic [7:0] host_exp; logic [7:0] tx_exp; int p; int dv; } exp_t;
  exp_t q[$];
  logic [7:0] fmask = 8'h00;

  int checks = 0, fails = 0, frames = 0, idle_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int divf(input logic [1:0] s);
    case (s) 2'b00: return 1; 2'b01: return 2; 2'b10: return 4; default: return 10; endcase
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // monitor: measure each frame and compare against the queue head
  task automatic capture_frame();
    int c = 0, rises = 0, first_rise = -1, hi_run = 0, width_bad = 0, p, dv;
    logic prev = 1'b0;
    logic [9:0] fr = '0;
    exp_t e;
    p  = (q.size() > 0) ? q[0].p  : BT;
    dv = (q.size() > 0) ? q[0].dv : 1;
    while (busy_n === 1'b0) begin
      int k = c / p;
      force_now = (k >= 1 && k <= 8) ? fmask[8-k] : 1'b0;
      if (k < 10 && (c % p) == p / 2) fr[k] = tx;
      if (sck && !prev) begin
        rises++;
        if (rises == 1) first_rise = c;
        hi_run = 1;
      end else if (sck) hi_run++;
      else if (prev && hi_run != (BT - 2 - HALF) * dv) width_bad++;
      prev = sck;
      c++;
      @(negedge clk);
    end
    force_now = 1'b0;
    frames++;
    repeat (2) @(negedge clk);
    if (q.size() == 0) begin
      chk(1'b0, "R8 unexpected frame", frames, 0);
      return;
    end
    e = q.pop_front();
    chk(c == 10 * e.p, "R6/R3 busy length", c, 10 * e.p);
    chk(fr[0] == 1'b0, "R2 start bit", fr[0], 0);
    chk(fr[8:1] == e.tx_exp, "R2 data slots", fr[8:1], e.tx_exp);
    chk(fr[9] == 1'b1, "R2 stop bit", fr[9], 1);
    chk(rises == 8, "R4 pulse count", rises, 8);
    chk(first_rise == e.p + (HALF + 1) * e.dv, "R4 first rise offset", first_rise, e.p + (HALF + 1) * e.dv);
    chk(width_bad == 0, "R4 high width", width_bad, 0);
    chk(hs == e.host_exp, "R5 reflected byte", hs, e.host_exp);
    chk(idle_bad == 0, "R9 mark between frames", idle_bad, 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (busy_n === 1'b1) begin
          if (tx !== 1'b1 || sck !== 1'b0) idle_bad++;
        end else capture_frame();
      end
    end
  end

  // driver: push expectation, then exercise the request handshake
  task automatic xfer(input logic [1:0] ds, input logic [7:0] h, input logic [7:0] f, input int mode);
    int p;
    div_sel = ds;
    p = BT * divf(ds);
    hs = h;
    fmask = f;
    q.push_back('{host_exp: h & ~f, tx_exp: rev8(h), p: p, dv: divf(ds)});
    if (mode == 1) begin
      idle = 1'b0;
      @(negedge clk) req_n = 1'b0;
      repeat (40) @(negedge clk);
      req_n = 1'b1;
      repeat (300) @(negedge clk);
      chk(busy_n == 1'b1, "R7 held while bus busy", busy_n, 1);
      idle = 1'b1;
    end else begin
      @(negedge clk) req_n = 1'b0;
    end
    while (busy_n !== 1'b0) @(negedge clk);
    @(negedge clk) req_n = 1'b1;
    if (mode == 2) begin
      repeat (3 * p) @(negedge clk);
      req_n = 1'b0;
      repeat (20) @(negedge clk);
      req_n = 1'b1;
    end
    if (mode == 3) begin
      repeat (2 * p) @(negedge clk);
      idle = 1'b0;
      repeat (p) @(negedge clk);
      idle = 1'b1;
    end
    while (busy_n !== 1'b1) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(sck == 1'b0, "R1 sck", sck, 0);
    chk(busy_n == 1'b1, "R1 busy", busy_n, 1);
    chk(tx == 1'b1, "R1 tx", tx, 1);
    chk(miso == 1'b1, "R1 miso", miso, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    xfer(2'b00, 8'hA5, 8'h00, 0);  // R3 /1
    xfer(2'b01, 8'h3C, 8'h00, 0);  // R3 /2
    xfer(2'b10, 8'h81, 8'h0F, 0);  // R5 collision, R3 /4
    xfer(2'b11, 8'hFF, 8'hA0, 0);  // R5, R3 /10
    xfer(2'b00, 8'h00, 8'h00, 0);
    xfer(2'b01, 8'h5A, 8'h00, 1);  // R7
    xfer(2'b01, 8'hC3, 8'h00, 2);  // R8
    xfer(2'b10, 8'h96, 8'h01, 3);  // R10

    repeat (400) @(negedge clk);
    chk(frames == 8, "R8 frame count", frames, 8);
    chk(q.size() == 0, "R10 all frames completed", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule